// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A watchdog peripheral on a simple 32-bit word register port. An interval counter of 2^N clock cycles runs only while two independent enable bits are both set. These are the primary enable, held in the first control word, and the secondary enable, reachable through either control word. When the interval elapses once, the block raises a warning flag and a level interrupt. If software does not service the timer and the interval elapses again, the block emits a fixed-width system reset pulse and records that a watchdog reset happened.

Software services the timer by writing a one to either flag position of the first control word. This clears the flag and starts the interval from zero. A third word returns a free-running cycle counter. Software can read it twice to confirm that the clock runs. A build option locks the enables once the timer runs, so software cannot stop it.

Top module: `twostage_watchdog`

## Requirements
- R1: After power-on reset (`rst` high), both control words read 0, `wdt_irq` is 0 and `wdt_reset` is 0.
- R2: A read request (`bus_valid`=1, `bus_write`=0) returns its data and `bus_rvalid`=1 one cycle later. Word index `bus_addr[3:2]`: 0 is control A, 1 is control B, 2 is the cycle counter, 3 reads 0. Control A holds the reset-record flag in bit 3, the warning flag in bit 2, the primary enable in bit 1 and the secondary enable in bit 0. Control B holds the secondary enable in bit 0 and reads 0 elsewhere.
- R3: The interval counts only while the primary and secondary enables are both 1. A write to bit 0 of either control word sets the secondary enable.
- R4: With the warning flag at 0, the warning flag and `wdt_irq` become 1 exactly 2^N cycles after the write that started the count. `wdt_irq` follows the warning flag as a level.
- R5: If the interval elapses while the warning flag is already 1, `wdt_reset` goes high for exactly RESET_PULSE_CYCLES (16) cycles and the reset-record flag becomes 1.
- R6: A control-A write with bit 2 or bit 3 set clears each flag written as 1 and restarts the interval from zero. The same write also loads both enables from bits 1 and 0.
- R7: Writing 0 to a flag bit leaves that flag unchanged.
- R8: When the count stops because an enable clears, the interval count returns to zero. A later start takes a full 2^N cycles to expire.
- R9: The cycle counter word increments every clock. Two reads issued d idle cycles apart differ by d+1.
- R10: With ENABLE_ONCE=1 and the timer running, writes that would clear either enable are ignored.
- R11: The reset-record flag stays 1 through the watchdog's own reset pulse. Only power-on reset or a write of 1 to bit 3 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_valid | input | 1 | Request strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the request |
| bus_rvalid | output | 1 | Marks read data on `bus_rdata` |
| wdt_irq | output | 1 | Warning interrupt, level |
| wdt_reset | output | 1 | System reset pulse |

## Verification
The hardest state to reach is the second expiry. The bench can only reach it by letting a full interval run out with the warning flag still set. Servicing, or stopping and restarting, at any time before that moves the deadline. The stimulus therefore counts cycles from the write that starts the count and samples one cycle before each deadline and at it. Separately, keepalives at random spacings just inside the interval confirm the deadline is never reached. A second instance built with the enable lock receives the same writes, so the stop attempts that halt the first instance are seen to have no effect on the second.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    // Field positions in control word A (bit 0 is shared with control word B)
    localparam int BIT_RREC  = 3;
    localparam int BIT_WARN  = 2;
    localparam int BIT_ENA   = 1;
    localparam int BIT_ENB   = 0;

    typedef enum logic [1:0] {
        SEL_CTLA  = 2'd0,
        SEL_CTLB  = 2'd1,
        SEL_TICKS = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     valid;
        logic     write;
        reg_sel_e sel;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic rrec;
        logic warn;
        logic ena;
        logic enb;
    } wdt_flags_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] addr);
        return reg_sel_e'(addr[3:2]);
    endfunction

    function automatic logic [DATA_W-1:0] ctla_word(input wdt_flags_t f);
        return {{(DATA_W-4){1'b0}}, f};
    endfunction

    function automatic logic [DATA_W-1:0] ctlb_word(input wdt_flags_t f);
        return {{(DATA_W-1){1'b0}}, f.enb};
    endfunction

endpackage

// File: rtl/wdt_ticks.sv
module wdt_ticks #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] ticks
);
    always_ff @(posedge clk) begin
        if (rst) ticks <= '0;
        else     ticks <= ticks + 1'b1;
    end
endmodule

// File: rtl/wdt_interval.sv
module wdt_interval #(
    parameter int INTERVAL_LOG2 = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic expire
);
    localparam logic [INTERVAL_LOG2-1:0] LAST = '1;

    logic [INTERVAL_LOG2-1:0] count;

    // A restart in the same cycle wins over the terminal count
    assign expire = run && !restart && (count == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) count <= '0;
        else                        count <= count + 1'b1;
    end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
#(
    parameter bit ENABLE_ONCE = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_req_t   req,
    input  logic       expire,
    output wdt_flags_t flags,
    output logic       running,
    output logic       restart,
    output logic       fire
);
    wdt_flags_t nxt;
    logic       wr_a, wr_b, locked;

    assign running = flags.ena && flags.enb;
    assign locked  = ENABLE_ONCE && running;
    assign wr_a    = req.valid && req.write && (req.sel == SEL_CTLA);
    assign wr_b    = req.valid && req.write && (req.sel == SEL_CTLB);
    assign restart = wr_a && (req.wdata[BIT_RREC] || req.wdata[BIT_WARN]);

    always_comb begin
        nxt  = flags;
        fire = 1'b0;
        if (expire) begin
            if (flags.warn) begin
                nxt.rrec = 1'b1;
                fire     = 1'b1;
            end else begin
                nxt.warn = 1'b1;
            end
        end
        if (wr_a) begin
            if (req.wdata[BIT_RREC]) nxt.rrec = 1'b0;
            if (req.wdata[BIT_WARN]) nxt.warn = 1'b0;
            if (req.wdata[BIT_ENA] || !locked) nxt.ena = req.wdata[BIT_ENA];
            if (req.wdata[BIT_ENB] || !locked) nxt.enb = req.wdata[BIT_ENB];
        end
        if (wr_b) begin
            if (req.wdata[BIT_ENB] || !locked) nxt.enb = req.wdata[BIT_ENB];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= nxt;
    end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(LEN);

    logic [CW-1:0] remain;

    assign pulse = (remain != '0);

    always_ff @(posedge clk) begin
        if (rst)         remain <= '0;
        else if (fire)   remain <= LOAD;
        else if (pulse)  remain <= remain - 1'b1;
    end
endmodule

// File: rtl/twostage_watchdog.sv
module twostage_watchdog
    import wdt_pkg::*;
#(
    parameter int INTERVAL_LOG2      = 8,
    parameter int RESET_PULSE_CYCLES = 16,
    parameter bit ENABLE_ONCE        = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              wdt_irq,
    output logic              wdt_reset
);
    bus_req_t          req;
    wdt_flags_t        flags;
    logic              running, restart, expire, fire;
    logic [DATA_W-1:0] tick_value;

    assign req.valid = bus_valid;
    assign req.write = bus_write;
    assign req.sel   = decode_sel(bus_addr);
    assign req.wdata = bus_wdata;

    wdt_ticks #(.W(DATA_W)) u_ticks (
        .clk(clk), .rst(rst), .ticks(tick_value)
    );

    wdt_interval #(.INTERVAL_LOG2(INTERVAL_LOG2)) u_interval (
        .clk(clk), .rst(rst), .run(running), .restart(restart), .expire(expire)
    );

    wdt_ctrl #(.ENABLE_ONCE(ENABLE_ONCE)) u_ctrl (
        .clk(clk), .rst(rst), .req(req), .expire(expire),
        .flags(flags), .running(running), .restart(restart), .fire(fire)
    );

    wdt_pulse #(.LEN(RESET_PULSE_CYCLES)) u_pulse (
        .clk(clk), .rst(rst), .fire(fire), .pulse(wdt_reset)
    );

    assign wdt_irq = flags.warn;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= req.valid && !req.write;
            if (req.valid && !req.write) begin
                case (req.sel)
                    SEL_CTLA:  bus_rdata <= ctla_word(flags);
                    SEL_CTLB:  bus_rdata <= ctlb_word(flags);
                    SEL_TICKS: bus_rdata <= tick_value;
                    default:   bus_rdata <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int PULSE_LEN   = 16,
    parameter bit ENABLE_ONCE = 1'b0
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [3:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        wdt_irq,
    input logic        wdt_reset,
    input logic        running,
    input logic        rrec,
    input logic [31:0] ticks
);
    localparam int HW = $clog2(PULSE_LEN + 1) + 1;

    logic [HW-1:0] high_cnt;
    logic          armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            high_cnt <= '0;
            armed    <= 1'b0;
        end else begin
            high_cnt <= wdt_reset ? high_cnt + 1'b1 : '0;
            armed    <= 1'b1;
        end
    end

    logic wr_a;
    assign wr_a = bus_valid && bus_write && (bus_addr[3:2] == 2'd0);

    // R5
    pulse_max_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_reset |-> (high_cnt < HW'(PULSE_LEN)));

    // R5
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wdt_reset) |-> (high_cnt == HW'(PULSE_LEN)));

    // R3
    idle_no_warn_chk: assert property (@(posedge clk) disable iff (rst)
        !running |=> !$rose(wdt_irq));

    // R6
    warn_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_a && bus_wdata[2]) |=> !wdt_irq);

    // R11
    rrec_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_a && bus_wdata[3]) |=> !rrec);

    // R11
    rrec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rrec && !(wr_a && bus_wdata[3])) |=> rrec);

    // R9
    ticks_step_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        ticks == $past(ticks) + 32'd1);

    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ENABLE_ONCE && running) |=> running);
endmodule

bind twostage_watchdog wdt_checker #(
    .PULSE_LEN(RESET_PULSE_CYCLES), .ENABLE_ONCE(ENABLE_ONCE)
) u_chk (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .wdt_irq(wdt_irq),
    .wdt_reset(wdt_reset), .running(running), .rrec(flags.rrec),
    .ticks(tick_value)
);

// File: tb/twostage_watchdog_test.sv
module twostage_watchdog_test;
    localparam int CLK_PERIOD = 10;
    localparam int NLOG = 8;
    localparam int M = 1 << NLOG;
    localparam logic [3:0] A_CTLA = 4'h0, A_CTLB = 4'h4, A_TICKS = 4'h8, A_NONE = 4'hC;

    logic clk = 1'b0, rst = 1'b1;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata, rdata_l;
    logic rvalid, rvalid_l, irq, irq_l, wreset, wreset_l;
    int total = 0, bad = 0;
    logic [31:0] r0, r1, r0l, r1l;

    always #(CLK_PERIOD/2) clk = ~clk;

    twostage_watchdog #(.INTERVAL_LOG2(NLOG), .RESET_PULSE_CYCLES(16), .ENABLE_ONCE(1'b0)) uut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
        .bus_rvalid(rvalid), .wdt_irq(irq), .wdt_reset(wreset));

    twostage_watchdog #(.INTERVAL_LOG2(NLOG), .RESET_PULSE_CYCLES(16), .ENABLE_ONCE(1'b1)) uut_once (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_l),
        .bus_rvalid(rvalid_l), .wdt_irq(irq_l), .wdt_reset(wreset_l));

    function automatic logic [31:0] exp_ctla(logic rrec, logic warn, logic ena, logic enb);
        return {28'd0, rrec, warn, ena, enb};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d, output logic [31:0] dl);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = rdata; dl = rdata_l;
    endtask

    initial begin
        repeat (100000) @(negedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seen, hi;
        void'($urandom(32'd2024));
        tick(3);
        rst = 1'b0;
        // R1 reset state
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 reset", {31'd0, wreset}, 0);
        rd(A_CTLA, r0, r0l); check("R1 ctla", r0, 0);
        check("R2 rvalid", {31'd0, rvalid}, 1);
        rd(A_CTLB, r0, r0l); check("R1 ctlb", r0, 0);
        rd(A_NONE, r0, r0l); check("R2 unused word", r0, 0);

        // R3 primary enable alone does not count
        wr(A_CTLA, 32'h2);
        tick(M + 10);
        check("R3 single enable irq", {31'd0, irq}, 0);
        rd(A_CTLA, r0, r0l); check("R2 ctla enables", r0, exp_ctla(0, 0, 1, 0));

        // R3/R4 secondary enable via control B starts the count
        wr(A_CTLB, 32'h1);
        tick(M - 1); check("R4 before deadline", {31'd0, irq}, 0);
        tick(1);     check("R4 at deadline", {31'd0, irq}, 1);
        check("R4 no reset yet", {31'd0, wreset}, 0);
        rd(A_CTLA, r0, r0l); check("R4 ctla warn", r0, exp_ctla(0, 1, 1, 1));
        rd(A_CTLB, r0, r0l); check("R2 ctlb mirror", r0, 1);
        tick(M - 3); check("R5 before second deadline", {31'd0, wreset}, 0);
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            tick(1);
            if (i == 0) check("R5 pulse start", {31'd0, wreset}, 1);
            if (wreset) hi++;
        end
        check("R5 pulse width", hi, 16);
        rd(A_CTLA, r0, r0l); check("R11 record after pulse", r0, exp_ctla(1, 1, 1, 1));

        // R7 writing zeros to flags keeps them
        wr(A_CTLA, 32'h3);
        rd(A_CTLA, r0, r0l); check("R7 zero write", r0, exp_ctla(1, 1, 1, 1));
        // R6 clear warn only; R11 record stays
        wr(A_CTLA, 32'h7);
        check("R6 irq cleared", {31'd0, irq}, 0);
        rd(A_CTLA, r0, r0l); check("R11 record kept", r0, exp_ctla(1, 0, 1, 1));
        wr(A_CTLA, 32'hB);
        rd(A_CTLA, r0, r0l); check("R11 record cleared", r0, exp_ctla(0, 0, 1, 1));

        // R6 restart: the 0xB write restarted; one read cycle already elapsed
        tick(M - 2); check("R6 restart before", {31'd0, irq}, 0);
        tick(1);     check("R6 restart deadline", {31'd0, irq}, 1);
        check("R6 first expiry no reset", {31'd0, wreset}, 0);
        wr(A_CTLA, 32'h7);

        // R6 random keepalives inside the interval
        seen = 0;
        for (int k = 0; k < 30; k++) begin
            int g;
            g = $urandom_range(M - 2, 0);
            for (int j = 0; j < g; j++) begin
                tick(1);
                if (irq || wreset) seen++;
            end
            wr(A_CTLA, 32'h7);
            if (irq || wreset) seen++;
        end
        check("R6 random keepalives", seen, 0);

        // R8 stop clears the count
        tick(M / 2);
        wr(A_CTLB, 32'h0);
        tick(M);
        check("R3 stopped", {31'd0, irq}, 0);
        wr(A_CTLB, 32'h1);
        tick(M - 1); check("R8 full interval", {31'd0, irq}, 0);
        tick(1);     check("R8 deadline", {31'd0, irq}, 1);
        wr(A_CTLA, 32'h7);

        // R9 cycle counter
        for (int k = 0; k < 8; k++) begin
            int d;
            d = $urandom_range(20, 0);
            rd(A_TICKS, r0, r0l);
            tick(d);
            rd(A_TICKS, r1, r1l);
            check("R9 tick delta", r1 - r0, 32'(d + 1));
        end

        // R10 lock: both instances running, try to stop
        wr(A_CTLA, 32'h7);
        wr(A_CTLB, 32'h0);
        wr(A_CTLA, 32'h0);
        rd(A_CTLA, r0, r0l);
        check("R10 unlocked stops", r0 & 32'h3, 0);
        check("R10 locked keeps enables", r0l & 32'h3, 3);

        // R1/R11 power-on reset clears everything
        rst = 1'b1; tick(2); rst = 1'b0;
        rd(A_CTLA, r0, r0l);
        check("R11 power-on clears", r0l, 0);
        check("R1 reset output", {31'd0, wreset_l}, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule